// File: doc/BRIEF.md
# Vsync-Swapped Ping-Pong Frame Store

This block holds two frame memories and gives each one a role. One is the front store, which the display side reads. The other is the back store, which a host fills with addressed pixel writes. The display side needs no address from outside, because the panel advances its own pointer on every pixel. A sequential scan counter therefore walks the front store from location zero to the last location and emits one pixel per cycle with a valid strobe. It raises a start-of-frame pulse when a scan begins and a frame-done pulse with the last pixel.

The host marks a finished frame with a one-cycle ready pulse. The roles of the two stores are exchanged only on the next rising edge of vertical sync. This means a frame is never shown half updated. From the ready pulse until that swap, host writes are held off by a stall output. A sync edge with no request pending leaves the roles as they are, so the panel is refreshed from the same store again.

Two finite-state machines do the work. The swap controller has the states `SWAP_IDLE` and `SWAP_PENDING`, with the transitions *request* (IDLE to PENDING on a ready pulse) and *exchange* (PENDING to IDLE on a sync edge). The scan reader has the states `SCAN_IDLE` and `SCAN_RUN`, with the transitions *start* (any state to RUN on a sync edge, counter cleared), *advance* (RUN to RUN with counter plus one) and *finish* (RUN to IDLE after the last location). The frame depth is a parameter. A full 800 by 480 panel uses 384000 locations.

Top module: `vsync_pingpong_fb`

## Requirements
- R1: After reset, `front_sel` is 0, and `host_stall`, `pix_valid`, `sof` and `frame_done` are all 0.
- R2: A host write (`host_we` high while `host_stall` is low) stores `host_data` at `host_addr` in the back store, which is store index `!front_sel`. It never alters the front store.
- R3: A `frame_ready` pulse seen in `SWAP_IDLE` with no sync edge in the same cycle drives `host_stall` high from the next cycle. `host_stall` stays high until the swap.
- R4: A host write presented while `host_stall` is high is dropped and changes no location.
- R5: On a vsync rising edge in `SWAP_PENDING`, `front_sel` toggles and `host_stall` drops, both visible in the cycle after the edge cycle.
- R6: A vsync rising edge with no pending request leaves `front_sel` unchanged, so the same store is scanned again.
- R7: Every vsync rising edge, including one in the middle of a scan, gives a one-cycle `sof` pulse in the cycle after the edge cycle and restarts the scan at location 0.
- R8: After the `sof` cycle, `pix_valid` is high for DEPTH consecutive cycles. `pix_data` carries front-store locations 0, 1, ..., DEPTH-1 in that order, each one cycle after its location was addressed.
- R9: `frame_done` is high only together with the pixel from location DEPTH-1. After it, `pix_valid` stays low until the next sync edge.
- R10: A `frame_ready` pulse in the same cycle as a vsync edge, with nothing pending, causes no swap at that edge. It leaves the request pending, so the swap happens at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host pixel write enable |
| host_addr | input | AW | Host write location |
| host_data | input | PW | Host write pixel value |
| host_stall | output | 1 | High while a swap request waits for vsync; writes are dropped |
| frame_ready | input | 1 | One-cycle pulse: back store holds a complete frame |
| vsync | input | 1 | Vertical sync level, synchronous to clk |
| front_sel | output | 1 | Index of the store currently scanned |
| sof | output | 1 | Start-of-frame pulse |
| pix_valid | output | 1 | Pixel strobe |
| pix_data | output | PW | Pixel value |
| frame_done | output | 1 | High with the last pixel of a scan |

## Verification
Several properties are checked on every cycle by assertions inside the RTL:
- Store roles change only on a sync edge while a request is pending.
- Accepted writes never reach the front store.
- Stalled writes reach no store.
- The scan counter stays within the frame.
- A valid pixel always follows an issued read.
- `frame_done` appears only with a valid pixel.

Other behaviour can only be shown by the bench's scenarios:
- The pixel order and values of a whole scan.
- The fact that a dropped write really left memory untouched.
- The restart of a scan mid-frame.
- The deferred swap when a ready pulse coincides with a sync edge.

The bench shows these by sweeping every location of a small frame in each scenario.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;

    typedef enum logic {
        SWAP_IDLE    = 1'b0,
        SWAP_PENDING = 1'b1
    } swap_state_e;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

endpackage

// File: rtl/fb_bank.sv
module fb_bank #(
    parameter int PW    = 16,
    parameter int DEPTH = 1024,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [PW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [PW-1:0] rd_data
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [PW-1:0] mem [DEPTH];

    // single write port, registered read port
    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr <= LAST)) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_addr <= LAST) begin
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/fb_swap_ctrl.sv
module fb_swap_ctrl
    import fbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_ready,
    input  logic vsync_edge,
    output logic front_sel,
    output logic host_stall
);
    swap_state_e state_q, state_d;
    logic        exchange;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SWAP_IDLE:    if (frame_ready) state_d = SWAP_PENDING;
            SWAP_PENDING: if (vsync_edge)  state_d = SWAP_IDLE;
            default:      state_d = SWAP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SWAP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        exchange   = 1'b0;
        host_stall = 1'b0;
        unique case (state_q)
            SWAP_IDLE: begin
                exchange   = 1'b0;
                host_stall = 1'b0;
            end
            SWAP_PENDING: begin
                exchange   = vsync_edge;
                host_stall = 1'b1;
            end
            default: begin
                exchange   = 1'b0;
                host_stall = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            front_sel <= 1'b0;
        end else if (exchange) begin
            front_sel <= ~front_sel;
        end
    end

    // R5: roles change only in the cycle after a sync edge
    p_swap_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(front_sel) |-> $past(vsync_edge));

    // R6: no swap without a pending request
    p_swap_needs_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(front_sel) |-> $past(host_stall));

    // R3: stall holds until a sync edge releases it
    p_stall_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stall && !vsync_edge) |=> host_stall);
endmodule

// File: rtl/fb_scan_reader.sv
module fb_scan_reader
    import fbuf_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsync_edge,
    output logic [AW-1:0] rd_addr,
    output logic          rd_issue,
    output logic          rd_last,
    output logic          sof
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    scan_state_e   state_q, state_d;
    logic [AW-1:0] addr_d;

    // next state and counter
    always_comb begin
        state_d = state_q;
        addr_d  = rd_addr;
        if (vsync_edge) begin
            state_d = SCAN_RUN;
            addr_d  = '0;
        end else begin
            unique case (state_q)
                SCAN_IDLE: begin
                    state_d = SCAN_IDLE;
                end
                SCAN_RUN: begin
                    if (rd_addr == LAST) begin
                        state_d = SCAN_IDLE;
                        addr_d  = '0;
                    end else begin
                        addr_d = rd_addr + 1'b1;
                    end
                end
                default: state_d = SCAN_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCAN_IDLE;
            rd_addr <= '0;
            sof     <= 1'b0;
        end else begin
            state_q <= state_d;
            rd_addr <= addr_d;
            sof     <= vsync_edge;
        end
    end

    // outputs
    always_comb begin
        rd_issue = 1'b0;
        rd_last  = 1'b0;
        unique case (state_q)
            SCAN_IDLE: begin
                rd_issue = 1'b0;
                rd_last  = 1'b0;
            end
            SCAN_RUN: begin
                rd_issue = 1'b1;
                rd_last  = (rd_addr == LAST);
            end
            default: begin
                rd_issue = 1'b0;
                rd_last  = 1'b0;
            end
        endcase
    end

    // R8: the scan counter never leaves the frame
    p_addr_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr <= LAST);

    // R7: a start pulse coincides with a scan at location zero
    p_sof_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (rd_issue && rd_addr == '0));
endmodule

// File: rtl/vsync_pingpong_fb.sv
module vsync_pingpong_fb #(
    parameter int PW    = 16,
    parameter int DEPTH = 1024,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [PW-1:0] host_data,
    output logic          host_stall,
    input  logic          frame_ready,
    input  logic          vsync,
    output logic          front_sel,
    output logic          sof,
    output logic          pix_valid,
    output logic [PW-1:0] pix_data,
    output logic          frame_done
);
    localparam int NBANK = 2;

    logic          vsync_q;
    logic          vsync_edge;
    logic [AW-1:0] rd_addr;
    logic          rd_issue;
    logic          rd_last;
    logic          sel_q;
    logic          last_q;
    logic          valid_q;
    logic [NBANK-1:0] bank_we;
    logic [PW-1:0] bank_rd [NBANK];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsync_q <= 1'b0;
        end else begin
            vsync_q <= vsync;
        end
    end
    assign vsync_edge = vsync & ~vsync_q;

    fb_swap_ctrl u_swap (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_ready(frame_ready),
        .vsync_edge (vsync_edge),
        .front_sel  (front_sel),
        .host_stall (host_stall)
    );

    fb_scan_reader #(.DEPTH(DEPTH), .AW(AW)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync_edge(vsync_edge),
        .rd_addr   (rd_addr),
        .rd_issue  (rd_issue),
        .rd_last   (rd_last),
        .sof       (sof)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_we[b] = host_we && !host_stall && (front_sel != 1'(b));
        fb_bank #(.PW(PW), .DEPTH(DEPTH), .AW(AW)) u_bank (
            .clk    (clk),
            .wr_en  (bank_we[b]),
            .wr_addr(host_addr),
            .wr_data(host_data),
            .rd_addr(rd_addr),
            .rd_data(bank_rd[b])
        );
    end

    // read-return stage, aligned with the bank's registered output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            last_q  <= 1'b0;
            sel_q   <= 1'b0;
        end else begin
            valid_q <= rd_issue;
            last_q  <= rd_last;
            sel_q   <= front_sel;
        end
    end

    assign pix_valid  = valid_q;
    assign frame_done = last_q;
    assign pix_data   = bank_rd[sel_q];

    // R2: accepted writes land in the back store only
    p_back_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we) && !bank_we[front_sel]);

    // R4: stalled writes reach no store
    p_stall_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_stall |-> (bank_we == '0));

    // R8: a pixel is valid only one cycle after its read was issued
    p_valid_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(rd_issue));

    // R9: frame done only with a valid pixel
    p_done_with_pixel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> pix_valid);
endmodule

// File: tb/vsync_pingpong_fb_tb.sv
module vsync_pingpong_fb_tb_top;
    localparam int PW    = 8;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [PW-1:0] host_data = '0;
    logic          host_stall;
    logic          frame_ready = 1'b0;
    logic          vsync = 1'b0;
    logic          front_sel;
    logic          sof;
    logic          pix_valid;
    logic [PW-1:0] pix_data;
    logic          frame_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vsync_pingpong_fb #(.PW(PW), .DEPTH(DEPTH), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
        .host_stall(host_stall), .frame_ready(frame_ready), .vsync(vsync),
        .front_sel(front_sel), .sof(sof), .pix_valid(pix_valid),
        .pix_data(pix_data), .frame_done(frame_done)
    );

    function automatic logic [PW-1:0] pat(int f, int i);
        return PW'((f * 37 + i * 5 + 3) & 8'hFF);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_px(int a, logic [PW-1:0] d);
        @(negedge clk);
        while (host_stall) @(negedge clk);
        host_we   = 1'b1;
        host_addr = AW'(a);
        host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic fill(int f);
        for (int i = 0; i < DEPTH; i++) write_px(i, pat(f, i));
    endtask

    // raise vsync for one cycle, then check one full scan
    task automatic run_frame(int f, bit restart, bit with_ready, bit exp_front);
        @(negedge clk);
        vsync = 1'b1;
        frame_ready = with_ready;
        @(negedge clk);
        vsync = 1'b0;
        frame_ready = 1'b0;
        chk("R7 sof after edge", sof, 1);
        chk("R5/R6 front after edge", front_sel, exp_front);
        if (!restart) chk("R9 idle before scan", pix_valid, 0);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            chk("R7 sof one cycle", sof, 0);
            chk("R8 valid", pix_valid, 1);
            chk("R8 pixel value", pix_data, pat(f, i));
            chk("R9 done position", frame_done, (i == DEPTH - 1));
        end
        @(negedge clk);
        chk("R9 valid low after frame", pix_valid, 0);
        @(negedge clk);
        chk("R9 valid stays low", pix_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 front", front_sel, 0);
        chk("R1 stall", host_stall, 0);
        chk("R1 valid", pix_valid, 0);
        chk("R1 sof", sof, 0);
        chk("R1 done", frame_done, 0);

        // R2: fill back store (index 1) with frame 1
        fill(1);

        // R3: request swap, stall rises next cycle
        @(negedge clk);
        frame_ready = 1'b1;
        @(negedge clk);
        frame_ready = 1'b0;
        chk("R3 stall after ready", host_stall, 1);
        // R4: write under stall must be dropped
        host_we = 1'b1; host_addr = 4'd3; host_data = 8'hEE;
        @(negedge clk);
        host_we = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 stall held", host_stall, 1);

        // R5, R8: swap and scan frame 1 (pixel 3 proves R4)
        run_frame(1, 0, 0, 1);
        chk("R5 stall released", host_stall, 0);

        // R2: fill new back store (index 0) with frame 2
        fill(2);

        // R6: no request, same store again; R2 front untouched
        run_frame(1, 0, 0, 1);
        chk("R6 stall low", host_stall, 0);

        // R10: ready with edge, no swap now
        run_frame(1, 0, 1, 1);
        chk("R10 request pending", host_stall, 1);

        // R10, R5: swap at following edge
        run_frame(2, 0, 0, 0);
        chk("R5 stall released 2", host_stall, 0);

        // R7: mid-scan restart
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 mid scan valid", pix_valid, 1);
        run_frame(2, 1, 0, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule